// File: doc/BRIEF.md
# Interrupt Acknowledge CPU Interface

This block is the processor-facing side of a small interrupt controller. It watches a bank of interrupt sources, each carrying an enable, a priority value, a trigger type (level or edge) and a secure/non-secure attribute. For every source it keeps a pending bit and an active bit. It arbitrates among the enabled, pending and not-yet-active sources, and it raises a single request line toward the processor when the winner is important enough to pass a priority mask.

Software reads an acknowledge port to claim the current winner. The read returns the winner's 10-bit ID and moves that source from pending to active. When there is nothing to hand over, the read returns a reserved ID instead and changes no state. This happens when the forwarding enable or the signalling enable is off, when nothing passes the mask, or when a race has already withdrawn the request. It also happens when the security state of the read differs from that of the winner. A later end-of-interrupt write naming the ID retires the active state.

Top module: `irq_ack_if`

## Requirements
- R1: After reset `irq_o` is low and `ack_id_o` reads 1023. An acknowledge read with no source asserted returns 1023.
- R2: A candidate is a source that is enabled, pending and not active. The winner is the candidate with the numerically lowest priority value, and ties go to the lowest ID. The winner qualifies only when its priority is strictly below `prio_mask_i`. `irq_o` is high exactly when a qualifying winner exists and both enables are on. A successful read returns the winner's ID.
- R3: While `fwd_en_i` is 0, `irq_o` is low and an acknowledge read returns 1023.
- R4: While `sig_en_i` is 0, `irq_o` is low and an acknowledge read returns 1023.
- R5: A secure read (`ack_secure_i`=1) whose winner is non-secure returns 1022. A non-secure read whose winner is secure returns 1023. Neither read acknowledges anything.
- R6: A level source (`src_edge_i` bit = 0) is pending while its input is high. Once the input falls and nothing else qualifies, `irq_o` drops and a read returns 1023.
- R7: Clearing a source's enable removes it from arbitration at once. A read afterwards returns 1023 if nothing else qualifies.
- R8: A successful read makes the source active, which excludes it from arbitration. An end-of-interrupt write with a matching ID clears the active state, and a level source still held high then competes again.
- R9: An edge source (`src_edge_i` bit = 1) latches pending on a 0-to-1 change of its input, and the pending bit is cleared when the source is acknowledged. Holding the input high does not latch pending again.
- R10: A read returning 1022 or 1023 changes no pending or active state, and it needs no end-of-interrupt write.
- R11: `ack_id_o` takes the response one cycle after the read strobe and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level_i | input | N_SRC | Raw source inputs |
| src_en_i | input | N_SRC | Per-source enable |
| src_edge_i | input | N_SRC | Trigger type per source: 1 = edge, 0 = level |
| src_secure_i | input | N_SRC | Security attribute per source: 1 = secure |
| src_prio_i | input | N_SRC*PRIO_W | Priority per source, source i in bits [i*PRIO_W +: PRIO_W]. A lower value wins. |
| fwd_en_i | input | 1 | Forwarding enable at the distributor level |
| sig_en_i | input | 1 | Signalling enable at the CPU interface |
| prio_mask_i | input | PRIO_W | Threshold: the winner must be strictly below it |
| ack_rd_i | input | 1 | Acknowledge read strobe |
| ack_secure_i | input | 1 | Security state of the read: 1 = secure |
| eoi_wr_i | input | 1 | End-of-interrupt write strobe |
| eoi_id_i | input | 10 | ID being retired |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_id_o | output | 10 | Registered response of the last acknowledge read |

## Verification
The hardest cases to reach are the races, where a request has been raised and then vanishes before the read. One way is a level input that falls. The other is an enable that is cleared while the source is pending. The bench builds each race on purpose: it raises a single source, confirms `irq_o`, withdraws the request in a quiet cycle and only then issues the read, so the response must come back spurious. Arbitration is swept over all 256 level patterns of eight sources. The priorities and masks are derived from the pattern index, so ties, masked winners and empty sets all occur.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] ID_NONE        = 10'd1023;
    localparam logic [ID_W-1:0] ID_WRONG_WORLD = 10'd1022;
    localparam int FIRST_RESERVED = 1020;
endpackage

// File: rtl/irq_src_state.sv
module irq_src_state #(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] level_i,
    input  logic [N_SRC-1:0] edge_mode_i,
    input  logic             grant_i,
    input  logic [IDX_W-1:0] grant_idx_i,
    input  logic             retire_i,
    input  logic [IDX_W-1:0] retire_idx_i,
    output logic [N_SRC-1:0] pend_o,
    output logic [N_SRC-1:0] act_o
);
    typedef struct packed {
        logic [N_SRC-1:0] pend;
        logic [N_SRC-1:0] act;
        logic [N_SRC-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        for (int i = 0; i < N_SRC; i++) begin
            if (edge_mode_i[i]) begin
                if (level_i[i] && !st_q.prev[i]) st_d.pend[i] = 1'b1;
                if (grant_i && grant_idx_i == IDX_W'(i)) st_d.pend[i] = 1'b0;
            end else begin
                st_d.pend[i] = level_i[i];
            end
            if (retire_i && retire_idx_i == IDX_W'(i)) st_d.act[i] = 1'b0;
            if (grant_i && grant_idx_i == IDX_W'(i)) st_d.act[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign act_o  = st_q.act;

    // R8: a source only turns active in the cycle after a grant
    assert_active_needs_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_i |=> ((st_q.act & ~$past(st_q.act)) == '0));

    // R9: an edge source never becomes pending without a rising input
    assert_edge_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_mode_i & ~(level_i & ~st_q.prev)) == edge_mode_i) && (edge_mode_i != '0)
        |=> ((st_q.pend & ~$past(st_q.pend) & $past(edge_mode_i)) == '0));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 4,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        cand_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    output logic                    found_o,
    output logic [IDX_W-1:0]        win_idx_o,
    output logic [PRIO_W-1:0]       win_prio_o
);
    always_comb begin
        found_o    = 1'b0;
        win_idx_o  = '0;
        win_prio_o = '1;
        for (int i = 0; i < N_SRC; i++) begin
            if (cand_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] < win_prio_o)) begin
                found_o    = 1'b1;
                win_idx_o  = IDX_W'(i);
                win_prio_o = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // R2: the reported winner is always one of the candidates
    assert_winner_is_candidate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> cand_i[win_idx_o]);
    // R2: nothing reported when the candidate set is empty
    assert_none_when_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_i == '0) |-> !found_o);
endmodule

// File: rtl/irq_ack_if.sv
module irq_ack_if #(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        src_level_i,
    input  logic [N_SRC-1:0]        src_en_i,
    input  logic [N_SRC-1:0]        src_edge_i,
    input  logic [N_SRC-1:0]        src_secure_i,
    input  logic [N_SRC*PRIO_W-1:0] src_prio_i,
    input  logic                    fwd_en_i,
    input  logic                    sig_en_i,
    input  logic [PRIO_W-1:0]       prio_mask_i,
    input  logic                    ack_rd_i,
    input  logic                    ack_secure_i,
    input  logic                    eoi_wr_i,
    input  logic [9:0]              eoi_id_i,
    output logic                    irq_o,
    output logic [9:0]              ack_id_o
);
    import irq_ack_pkg::*;

    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    typedef struct packed {
        logic [ID_W-1:0] ack_id;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [N_SRC-1:0]  pend, act, cand;
    logic              found, qual, deliver, win_sec, grant, retire;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_prio;

    assign cand    = pend & src_en_i & ~act;
    assign qual    = found && (win_prio < prio_mask_i);
    assign deliver = qual && fwd_en_i && sig_en_i;
    assign win_sec = src_secure_i[win_idx];
    assign retire  = eoi_wr_i && (eoi_id_i < ID_W'(N_SRC));
    assign irq_o   = deliver;

    irq_prio_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) arb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_i     (cand),
        .prio_i     (src_prio_i),
        .found_o    (found),
        .win_idx_o  (win_idx),
        .win_prio_o (win_prio)
    );

    irq_src_state #(.N_SRC(N_SRC)) state_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .level_i      (src_level_i),
        .edge_mode_i  (src_edge_i),
        .grant_i      (grant),
        .grant_idx_i  (win_idx),
        .retire_i     (retire),
        .retire_idx_i (eoi_id_i[IDX_W-1:0]),
        .pend_o       (pend),
        .act_o        (act)
    );

    always_comb begin
        st_d  = st_q;
        grant = 1'b0;
        if (ack_rd_i) begin
            if (!deliver) begin
                st_d.ack_id = ID_NONE;
            end else if (ack_secure_i && !win_sec) begin
                st_d.ack_id = ID_WRONG_WORLD;
            end else if (!ack_secure_i && win_sec) begin
                st_d.ack_id = ID_NONE;
            end else begin
                st_d.ack_id = ID_W'(win_idx);
                grant       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ack_id: ID_NONE};
        else        st_q <= st_d;
    end

    assign ack_id_o = st_q.ack_id;

    initial begin
        assert (N_SRC <= FIRST_RESERVED) else $error("source count reaches reserved IDs");
    end

    // R3: forwarding off gives a spurious answer
    assert_fwd_off_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd_i && !fwd_en_i |=> ack_id_o == ID_NONE);
    // R4: signalling off gives a spurious answer
    assert_sig_off_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd_i && !sig_en_i |=> ack_id_o == ID_NONE);
    // R5: secure read of a non-secure winner
    assert_secure_mismatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd_i && ack_secure_i && irq_o && !win_sec |=> ack_id_o == ID_WRONG_WORLD);
    // R10: a spurious answer leaves the active set untouched
    assert_spurious_no_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd_i && !irq_o |=> $stable(act));
    // R11: the response only moves on a read
    assert_hold_response_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_rd_i |=> $stable(ack_id_o));
endmodule

// File: tb/irq_ack_if_tb.sv
module irq_ack_if_tb_top;
    localparam int N  = 8;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  lvl = '0, en = '1, edg = '0, sec = '0;
    logic [N*PW-1:0] prio = '0;
    logic          fwd = 1'b1, sig = 1'b1;
    logic [PW-1:0] mask = 4'd15;
    logic          rd = 1'b0, rd_sec = 1'b0, eoi = 1'b0;
    logic [9:0]    eoi_id = '0;
    logic          irq;
    logic [9:0]    ack_id;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_ack_if #(.N_SRC(N), .PRIO_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_level_i(lvl), .src_en_i(en),
        .src_edge_i(edg), .src_secure_i(sec), .src_prio_i(prio),
        .fwd_en_i(fwd), .sig_en_i(sig), .prio_mask_i(mask),
        .ack_rd_i(rd), .ack_secure_i(rd_sec), .eoi_wr_i(eoi), .eoi_id_i(eoi_id),
        .irq_o(irq), .ack_id_o(ack_id)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack(input logic s, output int id);
        @(negedge clk); rd = 1'b1; rd_sec = s;
        @(negedge clk); rd = 1'b0; rd_sec = 1'b0;
        id = int'(ack_id);
    endtask

    task automatic do_eoi(input int id);
        @(negedge clk); eoi = 1'b1; eoi_id = 10'(id);
        @(negedge clk); eoi = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int id;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 ack_id after reset", int'(ack_id), 1023);
        do_ack(1'b0, id);
        chk("R1 empty read", id, 1023);

        // R2 sweep over all level patterns
        for (int p = 0; p < 256; p++) begin
            int best, bp, pv[N];
            logic [PW-1:0] m;
            m = PW'(p % 8);
            best = -1; bp = 99;
            for (int i = 0; i < N; i++) begin
                pv[i] = (i * 3 + p) % 6;
                prio[i*PW +: PW] = PW'(pv[i]);
                if (p[i] && pv[i] < bp) begin bp = pv[i]; best = i; end
            end
            mask = m;
            lvl = 8'(p);
            tick(2);
            chk("R2 irq sweep", int'(irq), (best >= 0 && bp < int'(m)) ? 1 : 0);
            do_ack(1'b0, id);
            chk("R2 winner sweep", id, (best >= 0 && bp < int'(m)) ? best : 1023);
            if (id < N) do_eoi(id);
            lvl = '0;
            tick(2);
        end
        mask = 4'd15;
        for (int i = 0; i < N; i++) prio[i*PW +: PW] = 4'd2;

        // R3 forwarding off
        lvl = 8'h01; tick(2);
        fwd = 1'b0; tick(1);
        chk("R3 irq fwd off", int'(irq), 0);
        do_ack(1'b0, id);
        chk("R3 read fwd off", id, 1023);
        fwd = 1'b1; tick(1);
        chk("R3 irq fwd back", int'(irq), 1);
        // R4 signalling off
        sig = 1'b0; tick(1);
        chk("R4 irq sig off", int'(irq), 0);
        do_ack(1'b0, id);
        chk("R4 read sig off", id, 1023);
        sig = 1'b1;
        do_ack(1'b0, id);
        chk("R10 state kept after spurious", id, 0);
        do_eoi(0); lvl = '0; tick(2);

        // R5 security mismatch
        lvl = 8'h10; tick(2);
        do_ack(1'b1, id);
        chk("R5 secure read non-secure winner", id, 1022);
        chk("R10 irq kept after 1022", int'(irq), 1);
        do_ack(1'b0, id);
        chk("R5 matching read", id, 4);
        do_eoi(4); lvl = '0; tick(2);
        sec = 8'h20; lvl = 8'h20; tick(2);
        do_ack(1'b0, id);
        chk("R5 non-secure read secure winner", id, 1023);
        chk("R10 irq kept after mismatch", int'(irq), 1);
        do_ack(1'b1, id);
        chk("R5 secure matching read", id, 5);
        do_eoi(5); lvl = '0; sec = '0; tick(2);

        // R6 level race
        lvl = 8'h40; tick(2);
        chk("R6 irq raised", int'(irq), 1);
        lvl = '0; tick(2);
        chk("R6 irq dropped", int'(irq), 0);
        do_ack(1'b0, id);
        chk("R6 read after deassert", id, 1023);

        // R7 enable cleared
        lvl = 8'h02; tick(2);
        chk("R7 irq raised", int'(irq), 1);
        en[1] = 1'b0; tick(1);
        chk("R7 irq after disable", int'(irq), 0);
        do_ack(1'b0, id);
        chk("R7 read after disable", id, 1023);
        en = '1; lvl = '0; tick(2);

        // R8 active exclusion and end of interrupt
        lvl = 8'h0A; tick(2);
        do_ack(1'b0, id);
        chk("R8 tie lowest id", id, 1);
        do_ack(1'b0, id);
        chk("R8 active excluded", id, 3);
        tick(3);
        chk("R11 response held", int'(ack_id), 3);
        do_ack(1'b0, id);
        chk("R8 all active", id, 1023);
        do_eoi(1);
        do_ack(1'b0, id);
        chk("R8 level source back after eoi", id, 1);
        do_eoi(1); do_eoi(3); lvl = '0; tick(2);

        // R9 edge source
        edg = 8'h04;
        lvl = 8'h04; tick(1);
        lvl = '0; tick(2);
        chk("R9 edge latched", int'(irq), 1);
        do_ack(1'b0, id);
        chk("R9 edge ack", id, 2);
        do_eoi(2);
        do_ack(1'b0, id);
        chk("R9 edge cleared", id, 1023);
        lvl = 8'h04; tick(2);
        do_ack(1'b0, id);
        chk("R9 second edge", id, 2);
        do_eoi(2); tick(2);
        chk("R9 held high no relatch irq", int'(irq), 0);
        do_ack(1'b0, id);
        chk("R9 held high no relatch", id, 1023);
        lvl = '0; edg = '0; tick(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule